// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block decides when an analog-to-digital converter begins a conversion sequence. Software loads a four-bit control word and can fire a one-cycle start request. The block also watches a trigger pin, which is the highest-numbered analog channel read as a digital level. It issues a one-cycle sequence-start pulse to the converter and holds a busy flag until the converter reports that the sequence is complete.

The control word selects one of six behaviours. With the trigger disabled, software can start a single sequence or an endless back-to-back run. With the trigger enabled, the pin either starts one sequence per active edge, or it gates continuous sequences for as long as it stays at its active level. The polarity field picks the active edge or level. In edge mode, an active edge that arrives while a sequence is still running is not acted on. It raises a sticky overrun flag that software clears by writing 1.

The pin is asynchronous. It passes through a synchronizer chain before any edge or level decision is made. Writing the control word always cancels any pending activity.

Top module: `adc_trig_seq`

## Requirements
- R1: `cfg_word` is captured on a cycle with `cfg_wr` high. Its fields are: bit 0 trigger enable, bit 1 level mode (1 = level, 0 = edge), bit 2 polarity (1 = rising/high, 0 = falling/low), bit 3 continuous scan.
- R2: With trigger disabled and scan clear, a `sw_start` pulse in idle produces one `seq_start` pulse on the next clock edge and raises `busy`. After `seq_done`, `busy` falls and no further start follows.
- R3: With trigger disabled and scan set, a `sw_start` pulse begins a run. Each accepted `seq_done` is followed on the next edge by a new `seq_start`, and `busy` stays high throughout.
- R4: With trigger enabled, edge mode and polarity 0, each falling edge of `ext_trig` seen in idle starts one sequence. Rising edges start nothing.
- R5: With trigger enabled, edge mode and polarity 1, each rising edge of `ext_trig` seen in idle starts one sequence. Falling edges start nothing.
- R6: With trigger enabled and level mode, sequences start and repeat on each `seq_done` while `ext_trig` is at the active level (low for polarity 0, high for polarity 1). Once the level is inactive, the running sequence ends at `seq_done` and no new one starts. Level mode never sets the overrun flag.
- R7: In edge mode, an active edge detected while `busy` is high sets `trig_ovr`. It neither starts nor queues a sequence. `trig_ovr` holds until an `ovr_clr` pulse. A set in the same cycle as a clear wins.
- R8: `ext_trig` passes through `SYNC_STAGES` (default 2) flops before detection. With the default, a start caused by a pin change appears after the third rising clock edge following that change.
- R9: `seq_start` is never high for two cycles in a row. It is issued only from idle, or on the edge that samples an accepted `seq_done`. A `seq_done` in the same cycle as `seq_start` is ignored.
- R10: `sw_start` has no effect while the trigger is enabled. `ext_trig` has no effect while the trigger is disabled.
- R11: A cycle with `cfg_wr` high returns the block to idle on the next edge, with `busy` and `seq_start` low, and ends any continuous run.
- R12: After reset, `seq_start`, `busy` and `trig_ovr` are low and the control word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_word | input | 4 | Control word (fields in R1) |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | Asynchronous trigger pin (top analog channel, digital read) |
| seq_done | input | 1 | Converter reports sequence complete |
| ovr_clr | input | 1 | Write-1 clear of the overrun flag |
| seq_start | output | 1 | One-cycle sequence start to the converter |
| busy | output | 1 | A sequence is in progress |
| trig_ovr | output | 1 | Sticky trigger overrun flag |

## Verification
The hardest case to reach is the clash between a new overrun and a software clear in the same cycle. The pin edge only becomes visible after the synchronizer delay, so the clear has to be timed against that internal latency rather than against the pin change. The stimulus raises the pin during a running sequence and counts two clock edges. It then drives `ovr_clr` so that the clear lands on the same edge as the registered overrun, and checks that the flag still reads set. A separate case gates a level-mode run and releases the level mid-sequence. It confirms that the sequence finishes and that nothing restarts and no overrun appears.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int CFG_W = 4;

    // packed MSB first: scan is bit 3, trig_en is bit 0
    typedef struct packed {
        logic scan;
        logic polarity;
        logic level_mode;
        logic trig_en;
    } cfg_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pin_s
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = pin;
        end else begin : g_many
            always_comb chain_d = {chain_q[LAST-1:0], pin};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_s = chain_q[LAST];
endmodule

// File: rtl/trig_qualify.sv
module trig_qualify (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic polarity,
    output logic act_edge,
    output logic act_level
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d    = pin_s;
        act_edge  = polarity ? (pin_s & ~prev_q) : (~pin_s & prev_q);
        act_level = (pin_s == polarity);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R8
    edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_edge |=> (!act_edge || !$stable(polarity)));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  cfg_t cfg_in,
    input  logic sw_start,
    input  logic seq_done,
    input  logic ovr_clr,
    input  logic act_edge,
    input  logic act_level,
    output logic polarity,
    output logic seq_start,
    output logic busy,
    output logic trig_ovr
);
    typedef struct packed {
        seq_state_e state;
        cfg_t       cfg;
        logic       cont;
        logic       start;
        logic       ovr;
    } regs_t;

    localparam regs_t REGS_RST = '{state: S_IDLE, cfg: '0, cont: 1'b0, start: 1'b0, ovr: 1'b0};

    regs_t cr_q, nx_d;
    logic  done_ok, again, fire, ovr_set;

    always_comb begin
        nx_d    = cr_q;
        nx_d.start = 1'b0;
        done_ok = seq_done && !cr_q.start;
        again   = cr_q.cfg.trig_en ? (cr_q.cfg.level_mode && act_level) : cr_q.cont;
        fire    = cr_q.cfg.level_mode ? act_level : act_edge;
        ovr_set = 1'b0;
        if (cfg_wr) begin
            nx_d.cfg   = cfg_in;
            nx_d.state = S_IDLE;
            nx_d.cont  = 1'b0;
        end else begin
            case (cr_q.state)
                S_IDLE: begin
                    if (!cr_q.cfg.trig_en) begin
                        if (sw_start || cr_q.cont) begin
                            nx_d.start = 1'b1;
                            nx_d.state = S_RUN;
                            nx_d.cont  = cr_q.cont | cr_q.cfg.scan;
                        end
                    end else if (fire) begin
                        nx_d.start = 1'b1;
                        nx_d.state = S_RUN;
                    end
                end
                S_RUN: begin
                    ovr_set = cr_q.cfg.trig_en && !cr_q.cfg.level_mode && act_edge;
                    if (done_ok) begin
                        if (again) nx_d.start = 1'b1;
                        else       nx_d.state = S_IDLE;
                    end
                end
                default: nx_d.state = S_IDLE;
            endcase
        end
        if (ovr_set)      nx_d.ovr = 1'b1;
        else if (ovr_clr) nx_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cr_q <= REGS_RST;
        else        cr_q <= nx_d;
    end

    assign polarity  = cr_q.cfg.polarity;
    assign seq_start = cr_q.start;
    assign busy      = (cr_q.state == S_RUN);
    assign trig_ovr  = cr_q.ovr;

    // R9
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);
    // R9
    start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_done) |=> !seq_start);
    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!busy && !seq_start));
    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_ovr && !ovr_clr) |=> trig_ovr);
    // R7
    ovr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_ovr && !busy) |=> !trig_ovr);
    // R6
    level_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_q.cfg.level_mode && !trig_ovr) |=> !trig_ovr);
    // R10
    sw_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_q.cfg.trig_en && !busy && !act_edge && !act_level) |=> !seq_start);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> busy);
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
    import adc_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             sw_start,
    input  logic             ext_trig,
    input  logic             seq_done,
    input  logic             ovr_clr,
    output logic             seq_start,
    output logic             busy,
    output logic             trig_ovr
);
    logic pin_s, act_edge, act_level, polarity;

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_trig), .pin_s(pin_s)
    );

    trig_qualify u_qual (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .polarity(polarity),
        .act_edge(act_edge), .act_level(act_level)
    );

    adc_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_in(cfg_t'(cfg_word)),
        .sw_start(sw_start), .seq_done(seq_done), .ovr_clr(ovr_clr),
        .act_edge(act_edge), .act_level(act_level), .polarity(polarity),
        .seq_start(seq_start), .busy(busy), .trig_ovr(trig_ovr)
    );
endmodule

// File: tb/adc_trig_seq_test.sv
module adc_trig_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_word = 4'h0;
    logic       sw_start = 1'b0;
    logic       ext_trig = 1'b0;
    logic       seq_done = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       seq_start, busy, trig_ovr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_trig_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .sw_start(sw_start), .ext_trig(ext_trig), .seq_done(seq_done),
        .ovr_clr(ovr_clr), .seq_start(seq_start), .busy(busy), .trig_ovr(trig_ovr)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input logic s, input logic b, input logic o);
        check(seq_start == s, {req, " seq_start"}, seq_start, s);
        check(busy == b, {req, " busy"}, busy, b);
        check(trig_ovr == o, {req, " trig_ovr"}, trig_ovr, o);
    endtask

    task automatic write_cfg(input logic [3:0] w);
        cfg_wr = 1'b1; cfg_word = w;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_done();
        seq_done = 1'b1;
        tick();
        seq_done = 1'b0;
    endtask

    task automatic count_starts(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (seq_start) c++;
        end
    endtask

    task automatic t_reset();
        expect_out("R12 reset", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_single();
        int c;
        write_cfg(4'b0000);
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        expect_out("R2 single start", 1'b1, 1'b1, 1'b0);
        tick();
        expect_out("R9 pulse width", 1'b0, 1'b1, 1'b0);
        count_starts(3, c);
        check(c == 0, "R9 no start while busy", c, 0);
        pulse_done();
        expect_out("R2 idle after done", 1'b0, 1'b0, 1'b0);
        count_starts(5, c);
        check(c == 0, "R2 single stops", c, 0);
        ext_trig = 1'b1; count_starts(4, c);
        ext_trig = 1'b0; begin int c2; count_starts(4, c2); c += c2; end
        check(c == 0, "R10 pin ignored when disabled", c, 0);
    endtask

    task automatic t_scan();
        int c;
        write_cfg(4'b1000);
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        expect_out("R3 scan first start", 1'b1, 1'b1, 1'b0);
        ext_trig = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick(); tick();
            pulse_done();
            expect_out("R3 back to back", 1'b1, 1'b1, 1'b0);
        end
        ext_trig = 1'b0;
        tick();
        write_cfg(4'b0000);
        expect_out("R11 abort scan", 1'b0, 1'b0, 1'b0);
        count_starts(5, c);
        check(c == 0, "R11 run ended", c, 0);
    endtask

    task automatic t_fall();
        int c;
        write_cfg(4'b0001);
        ext_trig = 1'b1;
        count_starts(5, c);
        check(c == 0, "R4 rising ignored", c, 0);
        ext_trig = 1'b0;
        tick(); check(seq_start == 1'b0, "R8 stage1", seq_start, 0);
        tick(); check(seq_start == 1'b0, "R8 stage2", seq_start, 0);
        tick();
        expect_out("R4 falling start", 1'b1, 1'b1, 1'b0);
        tick();
        pulse_done();
        expect_out("R4 done", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_rise();
        int c;
        write_cfg(4'b0101);
        sw_start = 1'b1; tick(); sw_start = 1'b0;
        count_starts(3, c);
        check(c == 0 && busy == 1'b0, "R10 sw ignored when enabled", c, 0);
        ext_trig = 1'b1;
        tick(); tick(); tick();
        expect_out("R5 rising start", 1'b1, 1'b1, 1'b0);
        tick();
        pulse_done();
        ext_trig = 1'b0;
        count_starts(5, c);
        check(c == 0, "R5 falling ignored", c, 0);
    endtask

    task automatic t_overrun();
        int c;
        ext_trig = 1'b1;
        tick(); tick(); tick();
        expect_out("R5 start before overrun", 1'b1, 1'b1, 1'b0);
        ext_trig = 1'b0; tick(); tick(); tick(); tick();
        ext_trig = 1'b1;
        tick(); tick(); tick();
        expect_out("R7 overrun set", 1'b0, 1'b1, 1'b1);
        tick();
        pulse_done();
        count_starts(5, c);
        check(c == 0, "R7 edge not queued", c, 0);
        check(trig_ovr == 1'b1, "R7 sticky", trig_ovr, 1);
        ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
        check(trig_ovr == 1'b0, "R7 cleared", trig_ovr, 0);
        ext_trig = 1'b0; tick(); tick(); tick();
        ext_trig = 1'b1; tick(); tick(); tick();
        check(seq_start == 1'b1, "R5 second start", seq_start, 1);
        ext_trig = 1'b0; tick(); tick(); tick(); tick();
        ext_trig = 1'b1; tick(); tick();
        ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
        check(trig_ovr == 1'b1, "R7 set beats clear", trig_ovr, 1);
        ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
        pulse_done();
        check(trig_ovr == 1'b0 && busy == 1'b0, "R7 clean end", trig_ovr, 0);
    endtask

    task automatic t_level();
        int c;
        write_cfg(4'b0011);
        count_starts(4, c);
        check(c == 0, "R6 inactive high", c, 0);
        ext_trig = 1'b0;
        tick(); tick(); tick();
        expect_out("R6 low active start", 1'b1, 1'b1, 1'b0);
        ext_trig = 1'b1; tick(); ext_trig = 1'b0;
        tick(); tick(); tick(); tick();
        pulse_done();
        expect_out("R6 repeat while active", 1'b1, 1'b1, 1'b0);
        ext_trig = 1'b1;
        tick(); tick(); tick(); tick();
        pulse_done();
        expect_out("R6 stop when inactive", 1'b0, 1'b0, 1'b0);
        count_starts(4, c);
        check(c == 0, "R6 no restart", c, 0);
        write_cfg(4'b0111);
        tick();
        expect_out("R1 high active start", 1'b1, 1'b1, 1'b0);
        tick();
        write_cfg(4'b0000);
        expect_out("R11 abort level", 1'b0, 1'b0, 1'b0);
        count_starts(4, c);
        check(c == 0, "R11 stays idle", c, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_single();
        t_scan();
        t_fall();
        t_rise();
        t_overrun();
        t_level();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule